// File: doc/BRIEF.md
# Start-Stop Framed Serial Link

This block is one serial link channel. On the transmit side it takes an 18-bit parallel word once per word period. It wraps the word with a leading start bit and a trailing stop bit, and shifts the resulting 20-bit frame out one bit per enabled bit period. The serial bit rate is modelled as a synchronous enable, `bit_en`, on a single clock. A frame therefore takes twenty enabled cycles, and a new word is taken at the start of every frame. The payload is 18 of every 20 line bits.

On the receive side the block shifts in the serial stream. It hunts for the frame boundary using only the start and stop bits. It declares lock once several consecutive frames line up at the same bit offset. While locked, it strips the framing bits and delivers each recovered word with a one-cycle strobe. A loopback control feeds the block's own serial output into its receiver in place of the external serial input, so the whole path can be tested without a line.

The receiver acquires alignment reliably when the link carries idle frames (all-zero data) during acquisition. In those frames the start bit is the only 1.

Top module: `ssfr_link`

## Requirements
- R1: `tx_load` is high on exactly one of every 20 enabled cycles, starting with the first enabled cycle after reset. `tx_data` is captured on the clock edge where `tx_load` is high.
- R2: Each frame on `ser_out` is sent in this order: the start bit (logic 1) first, then data bit 0 through data bit 17, then the stop bit (logic 0). Bit k of the frame appears on `ser_out` after the (k+1)th enabled edge, counting from the capture edge as the first.
- R3: A synchronous active-high `rst` drives `ser_out` to 0 (the stop level) and clears `rx_locked` and `rx_valid`. It also restarts the frame timing, so `tx_load` is high on the first enabled cycle after reset.
- R4: While `bit_en` is low, nothing advances. `ser_out` holds its value, `tx_load` is low, and `rx_valid` is low.
- R5: With `loopback`=1 the receiver takes `ser_out` and ignores `ser_in`. With `loopback`=0 it takes `ser_in`.
- R6: While unlocked, the receiver locks after 4 consecutive frames whose oldest bit is 1 and newest bit is 0, all at the same bit offset. The frame that completes lock gives no `rx_valid`, and the next good frame does. After a frame fails the test, the receiver slides its candidate offset by one bit.
- R7: `rx_valid` is a one-cycle pulse that is raised only while `rx_locked` is high. With it, `rx_data` carries frame bits 1 to 18, which are the 18 data bits.
- R8: While locked, a single frame with a wrong start bit or stop bit gives no `rx_valid` and keeps lock. The next good frame is delivered normally.
- R9: While locked, two consecutive bad frames drop `rx_locked` and restart the alignment search.
- R10: In loopback while locked, the word captured at one `tx_load` edge appears on `rx_data` with `rx_valid` right after the next `tx_load` edge, 20 enabled cycles later. One word is delivered per frame with no gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Serial bit-period enable |
| loopback | input | 1 | 1 routes `ser_out` into the receiver |
| tx_data | input | 18 | Word to transmit |
| tx_load | output | 1 | High on the cycle that `tx_data` is captured |
| ser_out | output | 1 | Serial line output |
| ser_in | input | 1 | External serial line input |
| rx_data | output | 18 | Recovered word |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| rx_locked | output | 1 | Receiver holds frame alignment |

## Verification
The serializer is first checked bit by bit with a word whose alternating pattern exposes any reversal of bit order or misplaced framing bit. Words with single set bits at either end, all ones, and mixed patterns are then looped back while the external input toggles, which tells the loopback path apart from the external input and catches dropped or shifted data bits. Frames driven by hand on the external input check the lock rules: one wrong stop bit, two wrong start bits in a row, and a count of idle frames during reacquisition. Together these separate keeping lock, dropping lock, and the exact frame on which lock is regained. A stall of the bit enable inside a frame and a reset while locked complete the set.

// File: rtl/ssfr_pkg.sv
package ssfr_pkg;
   localparam logic START_BIT = 1'b1;
   localparam logic STOP_BIT  = 1'b0;

   typedef enum logic {
      RX_HUNT  = 1'b0,
      RX_TRACK = 1'b1
   } rx_mode_e;
endpackage

// File: rtl/ssfr_tx.sv
module ssfr_tx
   import ssfr_pkg::*;
#(
   parameter int DATA_W = 18
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bit_en,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_load,
   output logic              ser_out
);
   localparam int FRAME_W = DATA_W + 2;
   localparam int CNT_W   = $clog2(FRAME_W);
   localparam logic [CNT_W-1:0] LAST_PH = CNT_W'(FRAME_W - 1);

   logic [CNT_W-1:0] phase_q;
   logic [DATA_W:0]  shift_q;
   logic             line_q;

   assign tx_load = bit_en && (phase_q == '0);
   assign ser_out = line_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= '0;
         shift_q <= '0;
         line_q  <= STOP_BIT;
      end else if (bit_en) begin
         phase_q <= (phase_q == LAST_PH) ? '0 : phase_q + 1'b1;
         if (phase_q == '0) begin
            line_q  <= START_BIT;
            shift_q <= {STOP_BIT, tx_data};
         end else begin
            line_q  <= shift_q[0];
            shift_q <= {STOP_BIT, shift_q[DATA_W:1]};
         end
      end
   end
endmodule

// File: rtl/ssfr_rx.sv
module ssfr_rx
   import ssfr_pkg::*;
#(
   parameter int DATA_W        = 18,
   parameter int LOCK_FRAMES   = 4,
   parameter int UNLOCK_MISSES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bit_en,
   input  logic              rx_bit,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              rx_locked
);
   localparam int FRAME_W = DATA_W + 2;
   localparam int CNT_W   = $clog2(FRAME_W);
   localparam int MCH_W   = $clog2(LOCK_FRAMES + 1);
   localparam int MIS_W   = $clog2(UNLOCK_MISSES + 1);
   localparam logic [CNT_W-1:0] LAST_PH   = CNT_W'(FRAME_W - 1);
   localparam logic [MCH_W-1:0] LOCK_LAST = MCH_W'(LOCK_FRAMES - 1);
   localparam logic [MIS_W-1:0] MISS_LAST = MIS_W'(UNLOCK_MISSES - 1);

   logic [FRAME_W-1:0] win_q, win_n;
   logic [CNT_W-1:0]   ph_q;
   logic [MCH_W-1:0]   match_q;
   logic [MIS_W-1:0]   miss_q;
   rx_mode_e           mode_q;
   logic [DATA_W-1:0]  data_q;
   logic               valid_q;
   logic               at_edge, frame_ok;

   // newest bit enters at the top; the oldest (start) sits at bit 0
   assign win_n    = {rx_bit, win_q[FRAME_W-1:1]};
   assign at_edge  = (ph_q == LAST_PH);
   assign frame_ok = (win_n[0] == START_BIT) && (win_n[FRAME_W-1] == STOP_BIT);

   assign rx_data   = data_q;
   assign rx_valid  = valid_q;
   assign rx_locked = (mode_q == RX_TRACK);

   always_ff @(posedge clk) begin
      if (rst) begin
         win_q   <= '0;
         ph_q    <= '0;
         match_q <= '0;
         miss_q  <= '0;
         mode_q  <= RX_HUNT;
         data_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (bit_en) begin
            win_q <= win_n;
            if (!at_edge) begin
               ph_q <= ph_q + 1'b1;
            end else if (mode_q == RX_TRACK) begin
               ph_q <= '0;
               if (frame_ok) begin
                  miss_q  <= '0;
                  valid_q <= 1'b1;
                  data_q  <= win_n[FRAME_W-2:1];
               end else if (miss_q == MISS_LAST) begin
                  mode_q  <= RX_HUNT;
                  miss_q  <= '0;
                  match_q <= '0;
                  ph_q    <= LAST_PH;       // slide one bit per test
               end else begin
                  miss_q <= miss_q + 1'b1;
               end
            end else begin
               if (frame_ok) begin
                  ph_q <= '0;
                  if (match_q == LOCK_LAST) begin
                     mode_q  <= RX_TRACK;
                     match_q <= '0;
                  end else begin
                     match_q <= match_q + 1'b1;
                  end
               end else begin
                  match_q <= '0;            // stay on the edge: next bit is next offset
               end
            end
         end
      end
   end
endmodule

// File: rtl/ssfr_link.sv
module ssfr_link #(
   parameter int DATA_W        = 18,
   parameter int LOCK_FRAMES   = 4,
   parameter int UNLOCK_MISSES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bit_en,
   input  logic              loopback,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_load,
   output logic              ser_out,
   input  logic              ser_in,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              rx_locked
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("ssfr_link: DATA_W must be at least 1");
      end
      if (LOCK_FRAMES < 1) begin : g_bad_lock
         $error("ssfr_link: LOCK_FRAMES must be at least 1");
      end
      if (UNLOCK_MISSES < 1) begin : g_bad_miss
         $error("ssfr_link: UNLOCK_MISSES must be at least 1");
      end
   endgenerate

   logic line_tx;
   logic line_rx;

   ssfr_tx #(.DATA_W(DATA_W)) u_tx (
      .clk     (clk),
      .rst     (rst),
      .bit_en  (bit_en),
      .tx_data (tx_data),
      .tx_load (tx_load),
      .ser_out (line_tx)
   );

   assign ser_out = line_tx;
   assign line_rx = loopback ? line_tx : ser_in;

   ssfr_rx #(
      .DATA_W        (DATA_W),
      .LOCK_FRAMES   (LOCK_FRAMES),
      .UNLOCK_MISSES (UNLOCK_MISSES)
   ) u_rx (
      .clk       (clk),
      .rst       (rst),
      .bit_en    (bit_en),
      .rx_bit    (line_rx),
      .rx_data   (rx_data),
      .rx_valid  (rx_valid),
      .rx_locked (rx_locked)
   );
endmodule

// File: rtl/ssfr_link_chk.sv
module ssfr_link_chk (
   input logic clk,
   input logic rst,
   input logic bit_en,
   input logic tx_load,
   input logic ser_out,
   input logic rx_valid,
   input logic rx_locked
);
   logic rst_d;
   always_ff @(posedge clk) rst_d <= rst;

   p_reset_state_r3: assert property (@(posedge clk) disable iff (rst)
      rst_d |-> (!ser_out && !rx_locked && !rx_valid));

   p_load_single_r1: assert property (@(posedge clk) disable iff (rst)
      tx_load |=> !tx_load);

   p_start_first_r2: assert property (@(posedge clk) disable iff (rst)
      tx_load |=> ser_out);

   p_stall_hold_r4: assert property (@(posedge clk) disable iff (rst)
      !bit_en |=> ($stable(ser_out) && !rx_valid));

   p_lock_quiet_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(rx_locked) |-> !rx_valid);

   p_valid_locked_r7: assert property (@(posedge clk) disable iff (rst)
      rx_valid |-> rx_locked);

   p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
      rx_valid |=> !rx_valid);

   p_unlock_quiet_r9: assert property (@(posedge clk) disable iff (rst)
      $fell(rx_locked) |-> !rx_valid);
endmodule

bind ssfr_link ssfr_link_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .bit_en    (bit_en),
   .tx_load   (tx_load),
   .ser_out   (ser_out),
   .rx_valid  (rx_valid),
   .rx_locked (rx_locked)
);

// File: tb/ssfr_link_tb.sv
module ssfr_link_tb;
   localparam int DW = 18;
   localparam int FW = DW + 2;
   localparam int NV = 8;

   // {ser_in level during loopback, word}
   localparam logic [DW:0] VEC [NV] = '{
      {1'b1, 18'h00001}, {1'b0, 18'h20000}, {1'b1, 18'h3FFFF}, {1'b1, 18'h15555},
      {1'b0, 18'h2AAAA}, {1'b1, 18'h0F0F0}, {1'b0, 18'h31C47}, {1'b1, 18'h00000}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic bit_en = 1'b1;
   logic loopback = 1'b1;
   logic [DW-1:0] tx_data = '0;
   logic ser_in = 1'b0;
   logic tx_load, ser_out, rx_valid, rx_locked;
   logic [DW-1:0] rx_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   ssfr_link u_dut (
      .clk(clk), .rst(rst), .bit_en(bit_en), .loopback(loopback),
      .tx_data(tx_data), .tx_load(tx_load), .ser_out(ser_out), .ser_in(ser_in),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_locked(rx_locked)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic frame_bit(input logic [DW-1:0] w, input int k);
      if (k == 0) return 1'b1;
      if (k == FW - 1) return 1'b0;
      return w[k-1];
   endfunction

   task automatic wait_load();
      while (!tx_load) @(negedge clk);
   endtask

   // drives one frame on ser_in, starting at the negedge after a load edge
   task automatic ext_frame(input logic st, input logic [DW-1:0] w, input logic sp);
      for (int k = 0; k < FW; k++) begin
         ser_in = (k == 0) ? st : (k == FW - 1) ? sp : w[k-1];
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] prev;
      logic held;
      int nfr;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R3 reset state
      chk(ser_out == 1'b0, "R3 ser_out", 32'(ser_out), 0);
      chk(rx_locked == 1'b0, "R3 rx_locked", 32'(rx_locked), 0);
      chk(rx_valid == 1'b0, "R3 rx_valid", 32'(rx_valid), 0);
      chk(tx_load == 1'b1, "R3 R1 first load", 32'(tx_load), 1);

      // R2 bit order of one frame
      tx_data = 18'h2D5A3;
      for (int k = 0; k < FW; k++) begin
         @(negedge clk);
         if (k == 0) tx_data = '0;
         chk(ser_out == frame_bit(18'h2D5A3, k), "R2 serial bit", 32'(ser_out),
             32'(frame_bit(18'h2D5A3, k)));
         if (k > 0 && k < FW - 1)
            chk(tx_load == 1'b0, "R1 load mid frame", 32'(tx_load), 0);
      end
      chk(tx_load == 1'b1, "R1 load period", 32'(tx_load), 1);

      // R6 acquisition on idle loopback frames
      nfr = 0;
      while (!rx_locked && nfr < 12) begin
         @(negedge clk);
         wait_load();
         nfr++;
      end
      chk(rx_locked == 1'b1, "R6 lock acquired", 32'(rx_locked), 1);

      // R10 R5 loopback table walk
      prev = '0;
      for (int i = 0; i < NV; i++) begin
         wait_load();
         tx_data = VEC[i][DW-1:0];
         ser_in  = VEC[i][DW];
         @(negedge clk);
         chk(rx_valid == 1'b1, "R10 valid per frame", 32'(rx_valid), 1);
         chk(rx_data == prev, "R10 R5 R7 loopback word", 32'(rx_data), 32'(prev));
         prev = VEC[i][DW-1:0];
         @(negedge clk);
         chk(rx_valid == 1'b0, "R7 single pulse", 32'(rx_valid), 0);
         if (i == 3) begin
            bit_en = 1'b0;
            held = ser_out;
            for (int s = 0; s < 6; s++) begin
               @(negedge clk);
               chk(ser_out == held && !tx_load && !rx_valid, "R4 stall",
                   {29'd0, ser_out, tx_load, rx_valid}, {29'd0, held, 2'b00});
            end
            bit_en = 1'b1;
         end
      end
      wait_load();
      tx_data = '0;
      @(negedge clk);
      chk(rx_data == prev && rx_valid, "R10 last word", 32'(rx_data), 32'(prev));

      // R5 external input, R8 single miss, R9 double miss
      loopback = 1'b0;
      tx_data  = 18'h3FFFF;
      ext_frame(1'b1, 18'h1F0F0, 1'b0);
      chk(rx_valid && rx_data == 18'h1F0F0, "R5 external word", 32'(rx_data), 32'h1F0F0);
      ext_frame(1'b1, 18'h00000, 1'b1);
      chk(rx_locked == 1'b1, "R8 lock kept", 32'(rx_locked), 1);
      chk(rx_valid == 1'b0, "R8 bad stop no valid", 32'(rx_valid), 0);
      ext_frame(1'b1, 18'h00F3C, 1'b0);
      chk(rx_valid && rx_data == 18'h00F3C, "R8 recovery word", 32'(rx_data), 32'h00F3C);
      ext_frame(1'b0, 18'h00000, 1'b0);
      chk(rx_locked == 1'b1 && !rx_valid, "R8 bad start keeps lock",
          32'({rx_locked, rx_valid}), 32'h2);
      ext_frame(1'b0, 18'h00000, 1'b0);
      chk(rx_locked == 1'b0, "R9 lock dropped", 32'(rx_locked), 0);

      // R6 exact reacquisition count
      for (int f = 1; f <= 4; f++) begin
         ext_frame(1'b1, 18'h00000, 1'b0);
         chk(rx_locked == (f == 4), "R6 lock on fourth frame", 32'(rx_locked),
             32'(f == 4));
         chk(rx_valid == 1'b0, "R6 R7 no valid before lock", 32'(rx_valid), 0);
      end
      ext_frame(1'b1, 18'h3A5C1, 1'b0);
      chk(rx_valid && rx_data == 18'h3A5C1, "R6 first word after lock",
          32'(rx_data), 32'h3A5C1);

      // R3 reset while locked
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(!rx_locked && !rx_valid && !ser_out, "R3 reset while locked",
          32'({rx_locked, rx_valid, ser_out}), 0);
      chk(tx_load == 1'b1, "R3 frame timing restart", 32'(tx_load), 1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule